// File: doc/BRIEF.md
# Forward-Euler Second-Order ODE Integrator

This block integrates y'' + 3·x·y' + 3·y = 0 numerically with the forward Euler method, in 32-bit signed fixed point with 16 fractional bits. A host places the initial abscissa, value, slope, step and interval end on the operand inputs and raises `start` for one cycle while the block is idle. The block then steps the solution forward until the abscissa reaches the interval end. When it finishes, it presents the final value on `y_out` together with a one-cycle `done` pulse.

The datapath has exactly one multiplier and one adder/subtractor/comparator. A fixed six-cycle schedule, driven by an eight-state controller, shares these two units across all the products and sums of one Euler step. Intermediate terms are kept in a few scratch registers. The whole step is committed at once at the end of the sixth cycle.

Top module: `euler_ode_core`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `done` is 0 and `y_out` is 0.
- R2: When `start` is 1 while `busy` is 0, the operands are captured at that clock edge and `busy` is 1 from the next cycle on.
- R3: Each Euler step takes exactly 6 cycles. For a run of N steps, `done` rises 6·N+1 cycles after the capture edge, and `busy` falls in that same cycle.
- R4: Every product is formed as the full signed product shifted right arithmetically by 16 bits and truncated to 32 bits. One step computes x1=x+dx, u1=(u−(3x·(u·dx)))−((3y)·dx) and y1=y+u·dx with 32-bit wrapping arithmetic, and the final `y_out` matches this bit for bit.
- R5: After each step the block continues only if x1 < a under a signed comparison. It stops on the first step where x1 ≥ a, including equality. At least one step always runs, even when a ≤ x at start.
- R6: `done` is high for exactly one cycle. `y_out` keeps the final value until a later run produces a new one.
- R7: A `start` raised while `busy` is 1 has no effect on the running computation, its timing or its result.
- R8: A reset during a run returns the block to idle in the next cycle, with `busy` and `done` low and no result produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; operands valid in the same cycle |
| x_in | input | 32 | Initial abscissa, Q16.16 |
| y_in | input | 32 | Initial value y(x), Q16.16 |
| u_in | input | 32 | Initial slope y'(x), Q16.16 |
| dx_in | input | 32 | Step size, Q16.16 |
| a_in | input | 32 | Interval end, Q16.16 |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when `y_out` is updated |
| y_out | output | 32 | Final y value of the last run, Q16.16 |

## Verification
On every cycle, the assertions check the handshake and timing properties. These are: `busy` follows an accepted start, `done` lasts a single cycle, the total busy time is a multiple of the six-cycle step plus one, `y_out` changes only with `done`, and the block is idle after reset. The numerical result, the stopping rule at and around the interval end, and the fact that a start during a run is ignored can only be shown by the bench. It compares, cycle by cycle, against an independent model of the loop for several step sizes and interval ends, including negative abscissas and the exact-equality stop.

// File: rtl/euler_pkg.sv
// Package: shared encodings for the Euler integrator.
// Assumes: all modules of the block import it; no state is held here.
package euler_pkg;

    // Controller states: idle/load, six schedule slots, result write
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P1,
        ST_P2,
        ST_P3,
        ST_P4,
        ST_P5,
        ST_P6,
        ST_WRITE
    } state_t;

    // Operation of the shared arithmetic unit
    typedef enum logic [1:0] {
        OP_ADD,
        OP_SUB,
        OP_LT
    } alu_op_t;

    // Operand sources available to both shared units
    typedef enum logic [3:0] {
        SRC_X,
        SRC_Y,
        SRC_U,
        SRC_DX,
        SRC_A,
        SRC_THREE,
        SRC_T3X,
        SRC_UDX,
        SRC_PROD,
        SRC_T3Y,
        SRC_X1,
        SRC_DIFF,
        SRC_QTERM
    } src_t;

    localparam int SRC_COUNT = 13;

    // Destinations of the multiplier result
    typedef enum logic [2:0] {
        MD_NONE,
        MD_T3X,
        MD_UDX,
        MD_PROD,
        MD_T3Y,
        MD_QTERM
    } mul_dst_t;

    // Destinations of the arithmetic unit result
    typedef enum logic [2:0] {
        AD_NONE,
        AD_X1,
        AD_FLAG,
        AD_Y1,
        AD_DIFF,
        AD_U
    } alu_dst_t;

endpackage

// File: rtl/euler_mul.sv
// Module: shared fixed-point multiplier.
// Does: a signed product of two Q(W-FRAC).FRAC words, shifted right by FRAC
// arithmetically and truncated to W bits. Purely combinational.
// Assumes: 0 < FRAC < W.
module euler_mul #(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] res
);
    localparam int PW = 2 * W;

    // Full-width signed product, rescaled and truncated in one expression
    assign res = W'(($signed({{W{op_a[W-1]}}, op_a}) * $signed({{W{op_b[W-1]}}, op_b})) >>> FRAC);

    initial begin
        if (FRAC <= 0 || FRAC >= W || PW != 2 * W) $error("euler_mul: bad FRAC");
    end
endmodule

// File: rtl/euler_alu.sv
// Module: shared add / subtract / signed less-than unit.
// Does: one of three operations per cycle, picked by the controller.
// Assumes: wrapping two's-complement arithmetic; the compare result is in bit 0.
module euler_alu
    import euler_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_t             op,
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] res
);
    // Select the operation result
    always_comb begin
        unique case (op)
            OP_ADD:  res = op_a + op_b;
            OP_SUB:  res = op_a - op_b;
            OP_LT:   res = {{(W-1){1'b0}}, (op_a < op_b)};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/euler_ctrl.sv
// Module: controller for the Euler integrator.
// Does: runs a fixed six-slot schedule per step and decodes the operand
// selects, destinations and ALU opcode from the state. Loops on the flag.
// Assumes: the flag is written in slot 2 and read in slot 6 of the same step.
module euler_ctrl
    import euler_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     c_flag,
    output logic     load,
    output logic     commit,
    output logic     wr_result,
    output logic     busy,
    output logic     done,
    output src_t     mul_sel_a,
    output src_t     mul_sel_b,
    output mul_dst_t mul_dst,
    output alu_op_t  alu_op,
    output src_t     alu_sel_a,
    output src_t     alu_sel_b,
    output alu_dst_t alu_dst
);
    state_t state_q, state_d;

    // State register and registered done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_WRITE);
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_P1;
            ST_P1:    state_d = ST_P2;
            ST_P2:    state_d = ST_P3;
            ST_P3:    state_d = ST_P4;
            ST_P4:    state_d = ST_P5;
            ST_P5:    state_d = ST_P6;
            ST_P6:    state_d = c_flag ? ST_P1 : ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Per-slot decode of the shared units
    always_comb begin
        mul_sel_a = SRC_X;
        mul_sel_b = SRC_THREE;
        mul_dst   = MD_NONE;
        alu_op    = OP_ADD;
        alu_sel_a = SRC_X;
        alu_sel_b = SRC_DX;
        alu_dst   = AD_NONE;
        unique case (state_q)
            ST_P1: begin
                mul_sel_a = SRC_X;    mul_sel_b = SRC_THREE; mul_dst = MD_T3X;
                alu_op = OP_ADD; alu_sel_a = SRC_X;  alu_sel_b = SRC_DX;  alu_dst = AD_X1;
            end
            ST_P2: begin
                mul_sel_a = SRC_U;    mul_sel_b = SRC_DX;    mul_dst = MD_UDX;
                alu_op = OP_LT;  alu_sel_a = SRC_X1; alu_sel_b = SRC_A;   alu_dst = AD_FLAG;
            end
            ST_P3: begin
                mul_sel_a = SRC_T3X;  mul_sel_b = SRC_UDX;   mul_dst = MD_PROD;
                alu_op = OP_ADD; alu_sel_a = SRC_Y;  alu_sel_b = SRC_UDX; alu_dst = AD_Y1;
            end
            ST_P4: begin
                mul_sel_a = SRC_Y;    mul_sel_b = SRC_THREE; mul_dst = MD_T3Y;
                alu_op = OP_SUB; alu_sel_a = SRC_U;  alu_sel_b = SRC_PROD; alu_dst = AD_DIFF;
            end
            ST_P5: begin
                mul_sel_a = SRC_T3Y;  mul_sel_b = SRC_DX;    mul_dst = MD_QTERM;
            end
            ST_P6: begin
                alu_op = OP_SUB; alu_sel_a = SRC_DIFF; alu_sel_b = SRC_QTERM; alu_dst = AD_U;
            end
            default: ;
        endcase
    end

    assign load      = (state_q == ST_IDLE) && start;
    assign commit    = (state_q == ST_P6);
    assign wr_result = (state_q == ST_WRITE);
    assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/euler_dp.sv
// Module: datapath of the Euler integrator.
// Does: holds the state variables and scratch terms, and routes them to the
// one multiplier and the one ALU as the controller selects.
// Assumes: the controller never asserts load and commit in the same cycle.
module euler_dp
    import euler_pkg::*;
#(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                commit,
    input  logic                wr_result,
    input  logic signed [W-1:0] x_in,
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] u_in,
    input  logic signed [W-1:0] dx_in,
    input  logic signed [W-1:0] a_in,
    input  src_t                mul_sel_a,
    input  src_t                mul_sel_b,
    input  mul_dst_t            mul_dst,
    input  alu_op_t             alu_op,
    input  src_t                alu_sel_a,
    input  src_t                alu_sel_b,
    input  alu_dst_t            alu_dst,
    output logic                c_flag,
    output logic signed [W-1:0] y_out
);
    localparam logic signed [W-1:0] THREE = W'(3) <<< FRAC;

    logic signed [W-1:0] x_q, y_q, u_q, dx_q, a_q;
    logic signed [W-1:0] t3x_q, udx_q, prod_q, t3y_q, qterm_q, x1_q, y1_q, diff_q;
    logic signed [W-1:0] src_vec [SRC_COUNT];
    logic signed [W-1:0] mul_a, mul_b, mul_res, alu_a, alu_b, alu_res;

    // Operand source table, indexed by the select encodings
    always_comb begin
        src_vec[SRC_X]     = x_q;
        src_vec[SRC_Y]     = y_q;
        src_vec[SRC_U]     = u_q;
        src_vec[SRC_DX]    = dx_q;
        src_vec[SRC_A]     = a_q;
        src_vec[SRC_THREE] = THREE;
        src_vec[SRC_T3X]   = t3x_q;
        src_vec[SRC_UDX]   = udx_q;
        src_vec[SRC_PROD]  = prod_q;
        src_vec[SRC_T3Y]   = t3y_q;
        src_vec[SRC_X1]    = x1_q;
        src_vec[SRC_DIFF]  = diff_q;
        src_vec[SRC_QTERM] = qterm_q;
    end

    assign mul_a = src_vec[mul_sel_a];
    assign mul_b = src_vec[mul_sel_b];
    assign alu_a = src_vec[alu_sel_a];
    assign alu_b = src_vec[alu_sel_b];

    euler_mul #(.W(W), .FRAC(FRAC)) u_mul (
        .op_a (mul_a),
        .op_b (mul_b),
        .res  (mul_res)
    );

    euler_alu #(.W(W)) u_alu (
        .op   (alu_op),
        .op_a (alu_a),
        .op_b (alu_b),
        .res  (alu_res)
    );

    // State variables: loaded on start, updated together at the end of a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            u_q  <= '0;
            dx_q <= '0;
            a_q  <= '0;
        end else if (load) begin
            x_q  <= x_in;
            y_q  <= y_in;
            u_q  <= u_in;
            dx_q <= dx_in;
            a_q  <= a_in;
        end else if (commit) begin
            x_q <= x1_q;
            y_q <= y1_q;
            if (alu_dst == AD_U) u_q <= alu_res;
        end
    end

    // Scratch terms written by the multiplier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t3x_q   <= '0;
            udx_q   <= '0;
            prod_q  <= '0;
            t3y_q   <= '0;
            qterm_q <= '0;
        end else begin
            unique case (mul_dst)
                MD_T3X:   t3x_q   <= mul_res;
                MD_UDX:   udx_q   <= mul_res;
                MD_PROD:  prod_q  <= mul_res;
                MD_T3Y:   t3y_q   <= mul_res;
                MD_QTERM: qterm_q <= mul_res;
                default:  ;
            endcase
        end
    end

    // Scratch terms and loop flag written by the ALU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x1_q   <= '0;
            y1_q   <= '0;
            diff_q <= '0;
            c_flag <= 1'b0;
        end else begin
            unique case (alu_dst)
                AD_X1:   x1_q   <= alu_res;
                AD_Y1:   y1_q   <= alu_res;
                AD_DIFF: diff_q <= alu_res;
                AD_FLAG: c_flag <= alu_res[0];
                default: ;
            endcase
        end
    end

    // Result port: updated only when the controller writes the result
    always_ff @(posedge clk) begin
        if (!rst_n)         y_out <= '0;
        else if (wr_result) y_out <= y_q;
    end
endmodule

// File: rtl/euler_ode_core.sv
// Module: top of the forward-Euler integrator for y'' + 3xy' + 3y = 0.
// Does: ties the controller to the datapath. One multiplier, one ALU.
// Assumes: operands are valid in the cycle where start is high and busy is low.
module euler_ode_core
    import euler_pkg::*;
#(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] x_in,
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] u_in,
    input  logic signed [W-1:0] dx_in,
    input  logic signed [W-1:0] a_in,
    output logic                busy,
    output logic                done,
    output logic signed [W-1:0] y_out
);
    logic     load, commit, wr_result, c_flag;
    src_t     mul_sel_a, mul_sel_b, alu_sel_a, alu_sel_b;
    mul_dst_t mul_dst;
    alu_dst_t alu_dst;
    alu_op_t  alu_op;

    euler_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .c_flag    (c_flag),
        .load      (load),
        .commit    (commit),
        .wr_result (wr_result),
        .busy      (busy),
        .done      (done),
        .mul_sel_a (mul_sel_a),
        .mul_sel_b (mul_sel_b),
        .mul_dst   (mul_dst),
        .alu_op    (alu_op),
        .alu_sel_a (alu_sel_a),
        .alu_sel_b (alu_sel_b),
        .alu_dst   (alu_dst)
    );

    euler_dp #(.W(W), .FRAC(FRAC)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .commit    (commit),
        .wr_result (wr_result),
        .x_in      (x_in),
        .y_in      (y_in),
        .u_in      (u_in),
        .dx_in     (dx_in),
        .a_in      (a_in),
        .mul_sel_a (mul_sel_a),
        .mul_sel_b (mul_sel_b),
        .mul_dst   (mul_dst),
        .alu_op    (alu_op),
        .alu_sel_a (alu_sel_a),
        .alu_sel_b (alu_sel_b),
        .alu_dst   (alu_dst),
        .c_flag    (c_flag),
        .y_out     (y_out)
    );
endmodule

// File: rtl/euler_ode_chk.sv
// Module: protocol and timing checker for euler_ode_core, bound to every instance.
// Does: watches the ports only; counts busy cycles to check the step length.
// Assumes: reset is held low for at least two cycles.
module euler_ode_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] y_out
);
    logic [31:0] busy_cnt;
    logic        rst_seen;

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 32'd1;
        else           busy_cnt <= '0;
    end

    // Remember that the previous edge saw reset
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // Idle outputs in the cycle after reset
    always @(posedge clk) begin
        if (rst_n && rst_seen) begin
            AST_IDLE_AFTER_RESET: assert (!busy && !done); // R8
        end
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_STEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt % 32'd6 == 32'd1)); // R3

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(y_out)); // R6
endmodule

bind euler_ode_core euler_ode_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .y_out (y_out)
);

// File: tb/euler_ode_core_bench.sv
`timescale 1ns/1ps
module euler_ode_core_bench;
    localparam int ONE = 65536;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [31:0] x_in = '0, y_in = '0, u_in = '0, dx_in = '0, a_in = '0;
    logic busy, done;
    logic signed [31:0] y_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic signed [31:0] last_y = '0;

    always #2 clk = ~clk;

    euler_ode_core u_euler_ode_core (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
        .busy(busy), .done(done), .y_out(y_out)
    );

    function automatic int mulq(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        return int'(p >>> 16);
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
            summary();
        end
    end

    // One run, compared against the model on every cycle
    task automatic run_case(string tag, int x, int y, int u, int dx, int a, bit poke_start);
        int steps = 0;
        int mx = x, my = y, mu = u, x1, udx, t3x, p, y1, d, t3y, q, u1;
        bit c;
        do begin
            x1 = mx + dx;
            t3x = mulq(mx, 3 * ONE);
            udx = mulq(mu, dx);
            p = mulq(t3x, udx);
            y1 = my + udx;
            d = mu - p;
            t3y = mulq(my, 3 * ONE);
            q = mulq(t3y, dx);
            u1 = d - q;
            c = (x1 < a);
            mx = x1; my = y1; mu = u1;
            steps++;
        end while (c);

        @(negedge clk);
        start = 1'b1; x_in = x; y_in = y; u_in = u; dx_in = dx; a_in = a;
        @(posedge clk);
        for (int k = 0; k <= 6 * steps + 3; k++) begin
            if (k > 0) @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (poke_start && k == 2) begin
                // R7: a start while busy, with different operands
                start = 1'b1; x_in = 5 * ONE; y_in = -7 * ONE; u_in = ONE; dx_in = ONE; a_in = 0;
            end
            // R2 R3: busy and done at every cycle
            check("R3", {tag, " busy"}, busy, (k <= 6 * steps) ? 1 : 0);
            check("R3", {tag, " done"}, done, (k == 6 * steps + 1) ? 1 : 0);
            if (k >= 6 * steps + 1) begin
                // R4 R5: final value; R6: held after the pulse
                check("R4", {tag, " y_out"}, y_out, my);
            end else if (k >= 1) begin
                check("R6", {tag, " y_out held"}, y_out, last_y);
            end
        end
        last_y = my;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "y_out", y_out, 0);
        rst_n = 1'b1;

        // R2 R4: basic run, dx=0.25, a=1.0 (four steps)
        run_case("R2 base", 0, ONE, 0, ONE / 4, ONE, 1'b0);
        // R4: finer step with a nonzero slope, plus a start while busy (R7)
        run_case("R7 finer", 0, ONE, ONE / 2, ONE / 8, ONE, 1'b1);
        // R5: a below x at start still runs one step
        run_case("R5 one-step", ONE, ONE / 2, -ONE, ONE / 4, ONE / 2, 1'b0);
        // R5: signed comparison with negative abscissa
        run_case("R5 negative", -ONE, ONE / 2, -ONE / 4, ONE / 2, 0, 1'b0);
        // R5: stop on exact equality x1 == a
        run_case("R5 equal", 0, 3 * ONE, ONE, ONE / 4, ONE / 2, 0);

        // R8: reset in the middle of a run
        @(negedge clk);
        start = 1'b1; x_in = 0; y_in = ONE; u_in = 0; dx_in = ONE / 16; a_in = ONE;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check("R8", "busy before reset", busy, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R8", "busy after reset", busy, 0);
        check("R8", "y_out after reset", y_out, 0);
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            check("R8", "no done after reset", done, 0);
        end
        summary();
    end
endmodule